// File: doc/BRIEF.md
# Single-Frame Receive Buffer with Host Register Port

This block holds one received frame between a MAC and a host processor that has no DMA engine. The MAC side writes the frame into an internal word store one 32-bit word at a time and then reports that the frame is complete. The completion carries a byte length, a general error flag and a CRC error flag. The block then marks the frame ready in a receive status/control register and raises the receive-ready interrupt cause.

The host reads the status word and drains the frame by reading a data port repeatedly. Each read returns the next word. The host reads ceil(length/4) words even for frames it intends to discard. It then writes zero to the status/control register, which frees the buffer for the next frame. While a frame waits for the host, the block refuses any new frame. The rejected completion is counted in a saturating overflow counter.

A second interrupt cause, transmit-done, is set from an input pulse and cleared by the host. Each cause is gated by its own enable bit, and the gated causes are combined into one interrupt line.

Top module: `rxfb_top`

## Requirements
- R1: After reset the status/control register, the cause register and the enable register read 0, `irq` is 0 and `ovf_count` is 0.
- R2: While no frame is ready, each `mac_wr_valid` word is stored in arrival order. A `mac_done` pulse latches `mac_len`, `mac_err` and `mac_crc_err` and sets the ready flag. The status/control register at byte offset 0x810 then reads as follows: length in bits 10:0, CRC error in bit 13, general error in bit 14, ready in bit 15, and all other bits 0.
- R3: Each read of the data port at offset 0x818, while a frame is ready and unread words remain, returns the next stored word in arrival order. Byte order is big-endian: the first byte of a word is in bits 31:24. When length mod 4 = k is nonzero, the last word of the frame (word index ceil(length/4)-1) keeps only its top k bytes, and its lower bytes read as 0.
- R4: A data-port read when no frame is ready, or when every stored word has already been read, returns 0. It does not advance the read position, so the next frame's words still start at word 0.
- R5: Writing the value 0 to the status/control register clears the ready flag, both error flags and the length, and discards any unread words. Writing any nonzero value to that register has no effect.
- R6: While the ready flag is set, MAC words are ignored and the stored frame is unchanged. A `mac_done` in that state leaves the status word unchanged and increments `ovf_count`, which saturates at its maximum.
- R7: Words offered after the store holds DEPTH words are ignored. The reported length is still the one given with `mac_done`.
- R8: The cause register at offset 0x8C4 reads the ready flag in bit 0 and the transmit-done cause in bit 1. A `tx_done_pulse` sets bit 1. Writing a 1 to bit 1 of the cause register clears it. Writes to bit 0 have no effect.
- R9: The enable register at offset 0x8C0 stores bits 1:0, and its other bits read 0. `irq` is the OR of (cause bit AND enable bit) over both bits, registered, and it follows a cause or enable change by one clock.
- R10: `bus_rdata` carries the result of a read request in the clock after the request. Reads of any unmapped offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_wr_valid | input | 1 | A frame word is offered this cycle |
| mac_wr_data | input | 32 | Frame word, first byte in bits 31:24 |
| mac_done | input | 1 | Frame complete pulse |
| mac_len | input | 11 | Frame length in bytes, valid with mac_done |
| mac_err | input | 1 | General receive error, valid with mac_done |
| mac_crc_err | input | 1 | CRC error, valid with mac_done |
| tx_done_pulse | input | 1 | Sets the transmit-done cause |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the request |
| irq | output | 1 | Combined enabled interrupt |
| ovf_count | output | OVF_W | Number of frames refused while the buffer was occupied |

## Verification
The bench builds the block with DEPTH = 8 words and OVF_W = 2. A depth of 8 words lets it sweep every frame length from 1 to 32 bytes, so every partial-word residue occurs at every word position, along with the error-flag combinations. It also reaches the full-store edge with an oversized frame in a few dozen cycles. The 2-bit counter is small enough that the bench drives it into saturation and checks that it stops there. The interrupt cases cover each enable combination with each cause, including clearing of the transmit cause and rejected writes to the receive cause.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam int ADDR_W = 13;
  localparam int LEN_W  = 11;

  localparam logic [ADDR_W-1:0] OFS_STAT  = 13'h810;
  localparam logic [ADDR_W-1:0] OFS_DATA  = 13'h818;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 13'h8C0;
  localparam logic [ADDR_W-1:0] OFS_CAUSE = 13'h8C4;

  typedef struct packed {
    logic             rdy;
    logic             err;
    logic             crc;
    logic [LEN_W-1:0] len;
  } rx_stat_t;

  function automatic logic [31:0] stat_word(rx_stat_t s);
    return {16'h0, s.rdy, s.err, s.crc, 2'b00, s.len};
  endfunction
endpackage

// File: rtl/rxfb_store.sv
module rxfb_store
  import rxfb_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [31:0]      wr_data,
  input  logic             done,
  input  logic [LEN_W-1:0] done_len,
  input  logic             done_err,
  input  logic             done_crc,
  input  logic             pop,
  input  logic             release_buf,
  output rx_stat_t         stat,
  output logic [31:0]      pop_data,
  output logic [OVF_W-1:0] ovf_cnt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int CW    = (PTR_W > LEN_W) ? PTR_W : LEN_W;

  logic [31:0]      mem [DEPTH];
  logic [31:0]      mem_q;
  logic [31:0]      mask_q;
  logic             pop_ok_q;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  logic             wr_en;
  logic             pop_ok;
  logic [CW-1:0]    rd_ext;
  logic [CW-1:0]    nwords;
  logic [31:0]      mask_d;

  assign wr_en  = wr_valid && !stat.rdy && (wr_ptr < PTR_W'(DEPTH));
  assign pop_ok = pop && stat.rdy && (rd_ptr != wr_ptr);
  assign rd_ext = CW'(rd_ptr);
  assign nwords = CW'(stat.len[LEN_W-1:2]) + CW'(|stat.len[1:0]);

  always_comb begin
    mask_d = 32'hFFFF_FFFF;
    if ((rd_ext + CW'(1)) == nwords && stat.len[1:0] != 2'b00)
      mask_d = ~(32'hFFFF_FFFF >> (8 * int'(stat.len[1:0])));
  end

  // word store, written and read synchronously
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) mem_q <= mem[rd_ptr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      stat     <= '0;
      ovf_cnt  <= '0;
      pop_ok_q <= 1'b0;
      mask_q   <= '0;
    end else begin
      pop_ok_q <= pop_ok;
      if (pop_ok) begin
        mask_q <= mask_d;
        rd_ptr <= rd_ptr + 1'b1;
      end
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (done) begin
        if (stat.rdy) begin
          if (ovf_cnt != '1) ovf_cnt <= ovf_cnt + 1'b1;
        end else begin
          stat.rdy <= 1'b1;
          stat.err <= done_err;
          stat.crc <= done_crc;
          stat.len <= done_len;
        end
      end
      if (release_buf) begin
        stat   <= '0;
        wr_ptr <= '0;
        rd_ptr <= '0;
      end
    end
  end

  assign pop_data = pop_ok_q ? (mem_q & mask_q) : 32'h0;

  // R7: the write position never passes the store depth
  assert_wr_bound_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ptr <= PTR_W'(DEPTH));

  // R3: reading never runs ahead of writing
  assert_rd_behind_wr_R3: assert property (@(posedge clk) disable iff (rst)
    rd_ptr <= wr_ptr);

  // R6: an occupied buffer keeps its contents until released
  assert_hold_while_ready_R6: assert property (@(posedge clk) disable iff (rst)
    stat.rdy && !release_buf |=> stat.rdy && $stable(wr_ptr) && $stable(stat.len));

  // R4: reading an empty buffer does not move the read position
  assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    pop && !release_buf && (rd_ptr == wr_ptr) |=> $stable(rd_ptr) && pop_data == 32'h0);
endmodule

// File: rtl/rxfb_regs.sv
module rxfb_regs
  import rxfb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  rx_stat_t          stat,
  input  logic [31:0]       pop_data,
  input  logic              tx_done_pulse,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              pop,
  output logic              release_buf
);
  logic        rd_req;
  logic        wr_req;
  logic [1:0]  ien_q;
  logic        tx_cause_q;
  logic [31:0] reg_q;
  logic        data_sel_q;
  logic [31:0] rd_mux;
  logic [1:0]  cause;

  assign rd_req      = bus_sel && !bus_wr;
  assign wr_req      = bus_sel && bus_wr;
  assign pop         = rd_req && bus_addr == OFS_DATA;
  assign release_buf = wr_req && bus_addr == OFS_STAT && bus_wdata == 32'h0;
  assign cause       = {tx_cause_q, stat.rdy};

  always_comb begin
    case (bus_addr)
      OFS_STAT:  rd_mux = stat_word(stat);
      OFS_IEN:   rd_mux = {30'h0, ien_q};
      OFS_CAUSE: rd_mux = {30'h0, cause};
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= '0;
      tx_cause_q <= 1'b0;
      reg_q      <= '0;
      data_sel_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      data_sel_q <= pop;
      reg_q      <= rd_req ? rd_mux : 32'h0;
      if (wr_req && bus_addr == OFS_IEN) ien_q <= bus_wdata[1:0];
      if (tx_done_pulse)
        tx_cause_q <= 1'b1;
      else if (wr_req && bus_addr == OFS_CAUSE && bus_wdata[1])
        tx_cause_q <= 1'b0;
      irq <= |(cause & ien_q);
    end
  end

  assign bus_rdata = data_sel_q ? pop_data : reg_q;

  // R9: with both enables off the line stays low
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
    ien_q == 2'b00 |=> !irq);

  // R5: a zero write to the status register frees the buffer
  assert_release_clears_R5: assert property (@(posedge clk) disable iff (rst)
    release_buf |=> !stat.rdy);

  // R8: a transmit-done pulse always leaves its cause set
  assert_tx_cause_set_R8: assert property (@(posedge clk) disable iff (rst)
    tx_done_pulse |=> tx_cause_q);
endmodule

// File: rtl/rxfb_top.sv
module rxfb_top
  import rxfb_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int OVF_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mac_wr_valid,
  input  logic [31:0]       mac_wr_data,
  input  logic              mac_done,
  input  logic [LEN_W-1:0]  mac_len,
  input  logic              mac_err,
  input  logic              mac_crc_err,
  input  logic              tx_done_pulse,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic [OVF_W-1:0]  ovf_count
);
  rx_stat_t    stat;
  logic [31:0] pop_data;
  logic        pop;
  logic        release_buf;

  rxfb_store #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_valid(mac_wr_valid), .wr_data(mac_wr_data),
    .done(mac_done), .done_len(mac_len), .done_err(mac_err), .done_crc(mac_crc_err),
    .pop(pop), .release_buf(release_buf),
    .stat(stat), .pop_data(pop_data), .ovf_cnt(ovf_count)
  );

  rxfb_regs u_regs (
    .clk(clk), .rst(rst),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .stat(stat), .pop_data(pop_data), .tx_done_pulse(tx_done_pulse),
    .bus_rdata(bus_rdata), .irq(irq), .pop(pop), .release_buf(release_buf)
  );
endmodule

// File: tb/test_rxfb_top.sv
module test_rxfb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int OVF_W = 2;
  localparam logic [12:0] A_STAT = 13'h810, A_DATA = 13'h818,
                          A_IEN = 13'h8C0, A_CAUSE = 13'h8C4;

  logic clk = 1'b0, rst = 1'b1;
  logic mac_wr_valid = 0, mac_done = 0, mac_err = 0, mac_crc_err = 0, tx_done_pulse = 0;
  logic [31:0] mac_wr_data = 0;
  logic [10:0] mac_len = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [12:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq;
  logic [OVF_W-1:0] ovf_count;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxfb_top #(.DEPTH(DEPTH), .OVF_W(OVF_W)) i_rxfb_top (
    .clk(clk), .rst(rst), .mac_wr_valid(mac_wr_valid), .mac_wr_data(mac_wr_data),
    .mac_done(mac_done), .mac_len(mac_len), .mac_err(mac_err), .mac_crc_err(mac_crc_err),
    .tx_done_pulse(tx_done_pulse), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ovf_count(ovf_count));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic push(logic [31:0] d);
    mac_wr_valid = 1; mac_wr_data = d;
    @(negedge clk);
    mac_wr_valid = 0;
  endtask

  task automatic finish_frame(int len, bit e, bit c);
    mac_done = 1; mac_len = 11'(len); mac_err = e; mac_crc_err = c;
    @(negedge clk);
    mac_done = 0;
  endtask

  function automatic logic [31:0] word_of(int f, int i);
    return 32'h0100_0000 * f + 32'h0001_0203 * i + 32'h0000_0011;
  endfunction

  function automatic logic [31:0] stat_exp(int len, bit e, bit c);
    return 32'h8000 + (e ? 32'h4000 : 0) + (c ? 32'h2000 : 0) + 32'(len);
  endfunction

  function automatic logic [31:0] mask_exp(int len, int i);
    int k = len % 4;
    int nw = (len + 3) / 4;
    if (k == 0 || i != nw - 1) return 32'hFFFF_FFFF;
    return 32'hFFFF_FFFF << (8 * (4 - k));
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    idle();
    // R1 reset state
    rd(A_STAT, d);  check("R1 stat", d, 0);
    rd(A_CAUSE, d); check("R1 cause", d, 0);
    rd(A_IEN, d);   check("R1 ien", d, 0);
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 ovf", {30'h0, ovf_count}, 0);
    // R4 empty read with no frame
    rd(A_DATA, d);  check("R4 empty", d, 0);
    // R10 unmapped
    rd(13'h900, d); check("R10 unmapped", d, 0);
    // R9 enable readback
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, d);   check("R9 ien bits", d, 3);
    wr(A_IEN, 32'h1);

    // R2 R3 R4 R5 R9: sweep every length that fits
    for (int len = 1; len <= DEPTH * 4; len++) begin
      int nw = (len + 3) / 4;
      bit e = len[0], c = len[1];
      for (int i = 0; i < nw; i++) push(word_of(len, i));
      finish_frame(len, e, c);
      rd(A_STAT, d);  check("R2 stat word", d, stat_exp(len, e, c));
      check("R9 irq on ready", {31'h0, irq}, 1);
      rd(A_CAUSE, d); check("R8 rx cause", d, 1);
      for (int i = 0; i < nw; i++) begin
        rd(A_DATA, d);
        check("R3 data", d, word_of(len, i) & mask_exp(len, i));
      end
      rd(A_DATA, d);  check("R4 drained", d, 0);
      wr(A_STAT, 0);
      idle();
      rd(A_STAT, d);  check("R5 cleared", d, 0);
      check("R9 irq off", {31'h0, irq}, 0);
    end

    // R5 nonzero write ignored; R6 overflow
    for (int i = 0; i < 2; i++) push(word_of(90, i));
    finish_frame(8, 0, 0);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d);  check("R5 nonzero write", d, stat_exp(8, 0, 0));
    for (int n = 1; n <= 4; n++) begin
      push(word_of(91, 0)); push(word_of(91, 1));
      finish_frame(20, 1, 1);
      rd(A_STAT, d); check("R6 stat kept", d, stat_exp(8, 0, 0));
      check("R6 ovf count", {30'h0, ovf_count}, (n > 3) ? 3 : n);
    end
    for (int i = 0; i < 2; i++) begin
      rd(A_DATA, d); check("R6 data kept", d, word_of(90, i));
    end
    wr(A_STAT, 0);

    // R7 oversized frame
    for (int i = 0; i < DEPTH + 2; i++) push(word_of(77, i));
    finish_frame(DEPTH * 4 + 8, 0, 1);
    rd(A_STAT, d);  check("R7 len", d, stat_exp(DEPTH * 4 + 8, 0, 1));
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, d); check("R7 data", d, word_of(77, i));
    end
    rd(A_DATA, d);  check("R7 extra read", d, 0);
    wr(A_STAT, 0);

    // R8 R9 transmit cause
    wr(A_IEN, 0);
    tx_done_pulse = 1; idle(); tx_done_pulse = 0;
    rd(A_CAUSE, d); check("R8 tx cause", d, 2);
    check("R9 masked", {31'h0, irq}, 0);
    wr(A_IEN, 2); idle();
    check("R9 tx irq", {31'h0, irq}, 1);
    wr(A_CAUSE, 1);
    rd(A_CAUSE, d); check("R8 bit0 write", d, 2);
    wr(A_CAUSE, 2); idle();
    rd(A_CAUSE, d); check("R8 cleared", d, 0);
    check("R9 irq cleared", {31'h0, irq}, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule